// File: doc/BRIEF.md
# Polled Port Space Status Table

This block keeps one "space available" bit for every downstream physical-layer port. In polled mode it drives a 3-bit poll address. The address runs through the configured port numbers in a fixed order and wraps around. Polling never stops, not even while a burst to some port is in progress. The port answers on one shared status line with a latency of one clock. The block pairs each answer with the address that was sent one cycle earlier and writes it into that port's table entry.

A status of 1 means the port's FIFO is not full and can take at least a preset minimum amount of data. A status of 0 means the FIFO is full or nearly full.

At build time a mode parameter chooses the status method, so only one method is ever active. In direct mode the block ignores the polled line, holds the poll address at zero and registers a per-port status vector every cycle. A transmit scheduler reads the table in two ways: as a vector, or through a single-port query.

Top module: `poll_status_table`

## Requirements
- R1: While reset is low, and after reset until a port's first answer is captured, every table bit reads 0 and the poll address reads 0.
- R2: In polled mode the poll address advances by one on every clock after reset, from 0 to NUM_PORTS-1, and then returns to 0. It never reaches NUM_PORTS or higher. NUM_PORTS is 1, 2, 4 or 8.
- R3: The status sampled on a clock edge is written into the table bit of the address that the block presented during the previous cycle. The new value is visible after that edge.
- R4: A capture changes at most one table bit per clock. Every other bit keeps its value until its own port is polled again.
- R5: `query_avail` returns the table bit of `query_port`. It is combinational. For a port number of NUM_PORTS or higher it returns 0.
- R6: In direct mode each table bit equals the corresponding `direct_status` bit sampled on the previous clock edge. The poll address stays at 0 and `poll_status` has no effect.
- R7: A table bit of 1 means the port has space for a burst. A table bit of 0 means the port is full or nearly full. The stored value is the status bit with no inversion.
- R8: Bits of `avail_vec` at positions NUM_PORTS and above always read 0, in both modes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| poll_adr | output | 3 | Port address being polled |
| poll_status | input | 1 | Answer to the address of the previous cycle (1 = space) |
| direct_status | input | 8 | Per-port status vector used in direct mode |
| query_port | input | 3 | Port number to look up |
| query_avail | output | 1 | Table bit of `query_port` |
| avail_vec | output | 8 | Whole table, bit i = port i |

## Verification
The hardest case to reach is a pairing error. A block that wrote each answer under the current address instead of the delayed one would still end up with the right table whenever all ports report the same value. To expose it, the bench models the port as a one-cycle registered lookup of a per-port pattern. It sweeps all sixteen patterns of a four-port configuration, and every cycle it checks the bit for the address seen two samples earlier. It also runs a phase in which only one port's status toggles at random, to show that the other entries hold.

// File: rtl/pst_pkg.sv
// Package: shared constants for the polled port status table.
// Assumes at most eight ports, so a 3-bit address is enough.
package pst_pkg;
    localparam int ADDR_W      = 3;
    localparam int VEC_W       = 1 << ADDR_W;
    localparam int MODE_POLLED = 0;
    localparam int MODE_DIRECT = 1;
endpackage

// File: rtl/pst_addr_gen.sv
// Poll address sequencer. It counts 0..NUM_PORTS-1 and wraps, and it keeps
// a copy of the address delayed by one cycle, plus a valid flag for that copy.
// The delayed copy and the flag tell the table which entry the current
// status answer belongs to.
// Assumes NUM_PORTS is 1, 2, 4 or 8. In direct mode all outputs stay at zero.
module pst_addr_gen
    import pst_pkg::*;
#(
    parameter int NUM_PORTS = 4,
    parameter int MODE      = MODE_POLLED
) (
    input  logic              clk,
    input  logic              rst_n,
    output logic [ADDR_W-1:0] adr,
    output logic [ADDR_W-1:0] adr_d,
    output logic              vld_d
);
    localparam logic [ADDR_W-1:0] LAST = ADDR_W'(NUM_PORTS - 1);

    logic [ADDR_W-1:0] adr_q;
    logic [ADDR_W-1:0] adr_dq;
    logic              vld_q;

    // Advance the poll address every cycle and wrap after the last port.
    always_ff @(posedge clk) begin
        if (!rst_n || MODE == MODE_DIRECT) begin
            adr_q <= '0;
        end else if (adr_q == LAST) begin
            adr_q <= '0;
        end else begin
            adr_q <= adr_q + 1'b1;
        end
    end

    // Remember the address the port sampled this edge; its answer comes next edge.
    always_ff @(posedge clk) begin
        if (!rst_n || MODE == MODE_DIRECT) begin
            adr_dq <= '0;
            vld_q  <= 1'b0;
        end else begin
            adr_dq <= adr_q;
            vld_q  <= 1'b1;
        end
    end

    assign adr   = adr_q;
    assign adr_d = adr_dq;
    assign vld_d = vld_q;

    generate
        if (MODE == MODE_POLLED) begin : g_poll_chk
            assert_wrap_R2: assert property (@(posedge clk) disable iff (!rst_n)
                (adr_q == LAST) |=> (adr_q == '0));
            assert_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
                (adr_q != LAST) |=> (adr_q == $past(adr_q) + 1'b1));
            assert_range_R2: assert property (@(posedge clk) disable iff (!rst_n)
                ({1'b0, adr_q} < 4'(NUM_PORTS)));
        end else begin : g_dir_chk
            assert_held_R6: assert property (@(posedge clk) disable iff (!rst_n)
                (adr_q == '0) && !vld_q);
        end
    endgenerate
endmodule

// File: rtl/pst_table.sv
// Status table. In polled mode it writes the answer into the entry named by
// the delayed address. In direct mode it registers the masked status vector.
// Entries for ports beyond NUM_PORTS are never written and stay at zero.
// Assumes adr_d is always below NUM_PORTS, which the sequencer guarantees.
module pst_table
    import pst_pkg::*;
#(
    parameter int NUM_PORTS = 4,
    parameter int MODE      = MODE_POLLED
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              vld_d,
    input  logic [ADDR_W-1:0] adr_d,
    input  logic              poll_status,
    input  logic [VEC_W-1:0]  dir_vec,
    output logic [VEC_W-1:0]  tbl
);
    localparam logic [VEC_W-1:0] MASK = VEC_W'((1 << NUM_PORTS) - 1);

    logic [VEC_W-1:0] tbl_q;

    // Update the table from the polled answer or from the direct vector.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tbl_q <= '0;
        end else if (MODE == MODE_DIRECT) begin
            tbl_q <= dir_vec & MASK;
        end else if (vld_d) begin
            tbl_q[adr_d] <= poll_status;
        end
    end

    assign tbl = tbl_q;

    assert_upper_zero_R8: assert property (@(posedge clk) disable iff (!rst_n)
        ((tbl_q & ~MASK) == '0));

    generate
        if (MODE == MODE_POLLED) begin : g_poll_chk
            assert_pairing_R3: assert property (@(posedge clk) disable iff (!rst_n)
                vld_d |=> (tbl_q[$past(adr_d)] == $past(poll_status)));
            assert_single_change_R4: assert property (@(posedge clk) disable iff (!rst_n)
                rst_n |=> ($countones(tbl_q ^ $past(tbl_q)) <= 1));
        end else begin : g_dir_chk
            assert_follow_R6: assert property (@(posedge clk) disable iff (!rst_n)
                rst_n |=> (tbl_q == ($past(dir_vec) & MASK)));
        end
    endgenerate
endmodule

// File: rtl/pst_query.sv
// Single-port lookup into the table for the transmit scheduler.
// Combinational. Port numbers at or above NUM_PORTS read as unavailable.
module pst_query
    import pst_pkg::*;
#(
    parameter int NUM_PORTS = 4
) (
    input  logic [ADDR_W-1:0] port,
    input  logic [VEC_W-1:0]  tbl,
    output logic              avail
);
    localparam logic [ADDR_W:0] NP = (ADDR_W + 1)'(NUM_PORTS);

    // Select the entry and gate it with the configured port range.
    always_comb begin
        avail = ({1'b0, port} < NP) && tbl[port];
    end
endmodule

// File: rtl/poll_status_table.sv
// Top of the polled port status table. It connects the address sequencer,
// the table and the query lookup.
// Assumes one clock domain shared with the polled ports, and that a port
// answers on the edge after it samples the address.
module poll_status_table
    import pst_pkg::*;
#(
    parameter int NUM_PORTS = 4,
    parameter int MODE      = MODE_POLLED
) (
    input  logic       clk,
    input  logic       rst_n,
    output logic [2:0] poll_adr,
    input  logic       poll_status,
    input  logic [7:0] direct_status,
    input  logic [2:0] query_port,
    output logic       query_avail,
    output logic [7:0] avail_vec
);
    logic [ADDR_W-1:0] adr_d;
    logic              vld_d;
    logic [VEC_W-1:0]  tbl;

    pst_addr_gen #(.NUM_PORTS(NUM_PORTS), .MODE(MODE)) u_adr (
        .clk   (clk),
        .rst_n (rst_n),
        .adr   (poll_adr),
        .adr_d (adr_d),
        .vld_d (vld_d)
    );

    pst_table #(.NUM_PORTS(NUM_PORTS), .MODE(MODE)) u_tbl (
        .clk         (clk),
        .rst_n       (rst_n),
        .vld_d       (vld_d),
        .adr_d       (adr_d),
        .poll_status (poll_status),
        .dir_vec     (direct_status),
        .tbl         (tbl)
    );

    pst_query #(.NUM_PORTS(NUM_PORTS)) u_qry (
        .port  (query_port),
        .tbl   (tbl),
        .avail (query_avail)
    );

    assign avail_vec = tbl;

    assert_query_range_R5: assert property (@(posedge clk) disable iff (!rst_n)
        ({1'b0, query_port} >= 4'(NUM_PORTS)) |-> !query_avail);
    assert_reset_clear_R1: assert property (@(posedge clk)
        !rst_n |=> (avail_vec == '0) && (poll_adr == '0));
endmodule

// File: tb/poll_status_table_tb.sv
`timescale 1ns/1ps
// Bench: four-port polled instance and four-port direct instance.
// The polled port is modelled as a one-cycle registered lookup of phy_pat.
module poll_status_table_tb;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [3:0] phy_pat = 4'h0;
    logic       ph_status = 1'b0;
    logic [7:0] dir_vec = 8'h00;
    logic [2:0] query_port = 3'd0;
    logic [2:0] poll_adr, dir_adr;
    logic       query_avail, dir_qa;
    logic [7:0] avail_vec, dir_avail;
    int checks = 0;
    int errors = 0;
    bit done = 0;

    always #2.5 clk = ~clk;

    // Port model: answers the sampled address on the following edge.
    always_ff @(posedge clk) ph_status <= phy_pat[poll_adr[1:0]];

    poll_status_table #(.NUM_PORTS(4), .MODE(0)) u_dut (
        .clk(clk), .rst_n(rst_n), .poll_adr(poll_adr), .poll_status(ph_status),
        .direct_status(8'hFF), .query_port(query_port),
        .query_avail(query_avail), .avail_vec(avail_vec));

    poll_status_table #(.NUM_PORTS(4), .MODE(1)) u_dut_dir (
        .clk(clk), .rst_n(rst_n), .poll_adr(dir_adr), .poll_status(ph_status),
        .direct_status(dir_vec), .query_port(query_port),
        .query_avail(dir_qa), .avail_vec(dir_avail));

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    logic [2:0] h_a [2];
    logic       h_v [2];
    logic       h_ok[2];

    // One clock: snapshot at this negedge, wait for the next, check the outputs.
    task automatic tick();
        logic [7:0] dv;
        logic [2:0] pa;
        logic [7:0] last_av;
        logic       ok0;
        h_a[1] = h_a[0]; h_v[1] = h_v[0]; h_ok[1] = h_ok[0];
        h_a[0] = poll_adr; h_v[0] = phy_pat[poll_adr[1:0]]; h_ok[0] = rst_n;
        dv = dir_vec; pa = poll_adr; ok0 = rst_n; last_av = avail_vec;
        @(posedge clk);
        @(negedge clk);
        if (ok0 && h_ok[1]) // R3: answer lands in the entry addressed one cycle earlier
            chk(avail_vec[h_a[1]] == h_v[1], "R3 pairing", avail_vec[h_a[1]], h_v[1]);
        if (ok0) begin
            chk(poll_adr == ((pa == 3'd3) ? 3'd0 : pa + 3'd1), "R2 step/wrap", poll_adr, (pa + 1) % 4);
            chk(dir_avail == (dv & 8'h0F), "R6 direct follow", dir_avail, dv & 8'h0F);
            chk(dir_adr == 3'd0, "R6 direct addr held", dir_adr, 0);
            chk($countones(avail_vec ^ last_av) <= 1, "R4 one change", avail_vec, last_av);
        end
        chk(avail_vec[7:4] == 4'h0 && dir_avail[7:4] == 4'h0, "R8 upper zero", {avail_vec[7:4], dir_avail[7:4]}, 0);
    endtask

    initial begin
        h_ok[0] = 0; h_ok[1] = 0; h_a[0] = 0; h_a[1] = 0; h_v[0] = 0; h_v[1] = 0;
        // R1: held in reset with every input asserted
        @(negedge clk);
        phy_pat = 4'hF; dir_vec = 8'hFF;
        repeat (3) tick();
        chk(avail_vec == 8'h00, "R1 reset table", avail_vec, 0);
        chk(dir_avail == 8'h00, "R1 reset direct table", dir_avail, 0);
        chk(poll_adr == 3'd0, "R1 reset addr", poll_adr, 0);
        rst_n = 1'b1;
        tick();
        chk(poll_adr == 3'd1, "R1/R2 first step", poll_adr, 1);
        chk(avail_vec == 8'h00, "R1 nothing captured yet", avail_vec, 0);
        tick();
        chk(avail_vec == 8'h01, "R1/R3 only port 0 captured", avail_vec, 1);
        // Sweep every pattern for the four ports
        for (int p = 0; p < 16; p++) begin
            phy_pat = 4'(p);
            for (int k = 0; k < 6; k++) begin
                dir_vec = 8'($urandom);
                tick();
            end
            chk(avail_vec == {4'h0, 4'(p)}, "R3/R7 settled table", avail_vec, p);
            for (int q = 0; q < 8; q++) begin
                query_port = 3'(q);
                #0.5;
                chk(query_avail == ((q < 4) ? phy_pat[q[1:0]] : 1'b0), "R5/R7 query",
                    query_avail, (q < 4) ? phy_pat[q[1:0]] : 0);
            end
        end
        // R4: only port 0 toggles; ports 1..3 must hold their entries
        phy_pat = 4'b1010;
        repeat (6) tick();
        for (int k = 0; k < 120; k++) begin
            phy_pat[0] = 1'($urandom);
            tick();
            chk(avail_vec[3:1] == 3'b101, "R4 others hold", avail_vec[3:1], 5);
        end
        // R6: the direct instance ignores the polled line
        dir_vec = 8'h00;
        for (int k = 0; k < 8; k++) begin
            phy_pat = 4'(k * 5);
            tick();
            chk(dir_avail == 8'h00, "R6 polled line ignored", dir_avail, 0);
        end
        // Reset again in mid-run, then release
        rst_n = 1'b0;
        tick();
        chk(avail_vec == 8'h00 && poll_adr == 3'd0, "R1 re-reset", avail_vec, 0);
        rst_n = 1'b1;
        phy_pat = 4'b0110;
        repeat (8) tick();
        chk(avail_vec == 8'h06, "R3 after re-reset", avail_vec, 6);
        done = 1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        #(200000 * 5);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule